// File: doc/BRIEF.md
# Disk Interface Command and Status Register Block

This block is the host-visible register file of a disk-drive interface controller. A host reaches it over a simple 32-bit register bus that carries a write strobe, a read strobe, a register index, write data and a four-bit byte enable. Most registers are plain storage. Three of them act on the words written to them.

The combined command/status register recognises the three clock-read commands. Each one sets a mechanism-interrupt status flag and raises a level interrupt toward the CPU. The buffer-manager control/status register treats three control words as actions that drop the interrupt line and are not stored. A hard-reset register accepts only a magic word. That word forces the buffer-manager register to a fixed pattern. Any other value written there is refused and recorded on a sticky error output.

Read data appears one cycle after the read strobe, and reads never change state. The block is used by software that issues clock-read commands, waits for the interrupt, and acknowledges it through the control register.

Top module: `dctl_regblock`

## Requirements
- R1: While rst_n is low at a clock edge, every register is cleared to zero, irq_o goes low and proto_err_o goes low.
- R2: A read strobe with index i returns the value of register i on rd_data one clock later. Reading changes no register, irq_o or proto_err_o.
- R3: The plain registers are at indices 0, 1, 3, 5, 6 and 7. A write to one of them replaces byte b (bits 8b+7:8b) only where wr_be[b] is 1, and keeps the other bytes.
- R4: The command/status register is at index 2. Writing 0x00120000, 0x00130000 or 0x00140000 there stores the word under the byte enables, also sets bit 25 (0x02000000), and drives irq_o high from the next cycle.
- R5: Any other word written to index 2 is stored under the byte enables with no extra bits, and irq_o keeps its value.
- R6: The buffer-manager register is at index 4. Writing 0x10000000 there clears its bit 29 (0x20000000), leaves its other bits unchanged, is not stored, and drives irq_o low.
- R7: Writing 0x01000000 to index 4 clears bit 25 of the command/status register, leaves the buffer-manager register unchanged, and drives irq_o low.
- R8: Writing 0x00000000 to index 4 drives irq_o low and changes no stored bit.
- R9: Any other word written to index 4 is merged under the byte enables and leaves irq_o unchanged.
- R10: The hard-reset register is at index 8. Writing 0xAAAA0000 there loads the buffer-manager register with exactly 0x00400000. Index 8 always reads 0.
- R11: Writing any value other than 0xAAAA0000 to index 8 changes no register and sets proto_err_o. proto_err_o then stays high until reset.
- R12: Indices 9 to 15 hold nothing. Writes to them change no register, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_idx | input | 4 | Register index |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq_o | output | 1 | Level interrupt toward the CPU |
| proto_err_o | output | 1 | Sticky flag for a refused hard-reset write |

## Verification
The hardest situation to reach is an acknowledge that lands while the interrupt is already pending. In that case the control word must clear a flag held in a different register and must not be stored itself. To get there, the stimulus first raises the interrupt with a clock-read command. It then writes each acknowledge word, reads back both the command/status register and the buffer-manager register, and compares them with values it has already set up. It also writes an unrecognised command while the interrupt is pending, to show that the line holds.

// File: rtl/dctl_pkg.sv
// Package: shared constants and write-class type for the disk interface
// register block. Assumes a 32-bit data path split into 8-bit lanes.
package dctl_pkg;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int N_STORE = 8;
    localparam int STORE_W = $clog2(N_STORE);

    localparam int IDX_CMD  = 2;
    localparam int IDX_BMGR = 4;
    localparam int IDX_HRST = 8;

    localparam logic [DATA_W-1:0] CMD_CLK_YM   = 32'h0012_0000;
    localparam logic [DATA_W-1:0] CMD_CLK_DH   = 32'h0013_0000;
    localparam logic [DATA_W-1:0] CMD_CLK_MS   = 32'h0014_0000;
    localparam logic [DATA_W-1:0] ST_MECH_INT  = 32'h0200_0000;
    localparam logic [DATA_W-1:0] BM_RESET_W   = 32'h1000_0000;
    localparam logic [DATA_W-1:0] BM_MECHA_W   = 32'h0100_0000;
    localparam logic [DATA_W-1:0] BM_INTMASK   = 32'h2000_0000;
    localparam logic [DATA_W-1:0] BM_C1_DOUBLE = 32'h0040_0000;
    localparam logic [DATA_W-1:0] HRST_MAGIC   = 32'hAAAA_0000;

    typedef enum logic [3:0] {
        WC_NONE,
        WC_PLAIN,
        WC_CMD_CLK,
        WC_CMD_OTHER,
        WC_BM_RESET,
        WC_BM_MECHA,
        WC_BM_ZERO,
        WC_BM_OTHER,
        WC_HR_MAGIC,
        WC_HR_BAD,
        WC_VOID
    } wclass_e;
endpackage

// File: rtl/dctl_wdecode.sv
// Module: classifies a bus write by target register and data word.
// Assumes a single write per cycle; an idle bus yields WC_NONE.
module dctl_wdecode
    import dctl_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    output wclass_e           wclass
);
    // Purpose: map (index, word) to one action class.
    always_comb begin
        wclass = WC_NONE;
        if (wr_en) begin
            if (int'(reg_idx) == IDX_CMD) begin
                if (wr_data == CMD_CLK_YM || wr_data == CMD_CLK_DH ||
                    wr_data == CMD_CLK_MS)
                    wclass = WC_CMD_CLK;
                else
                    wclass = WC_CMD_OTHER;
            end else if (int'(reg_idx) == IDX_BMGR) begin
                if (wr_data == BM_RESET_W)
                    wclass = WC_BM_RESET;
                else if (wr_data == BM_MECHA_W)
                    wclass = WC_BM_MECHA;
                else if (wr_data == '0)
                    wclass = WC_BM_ZERO;
                else
                    wclass = WC_BM_OTHER;
            end else if (int'(reg_idx) == IDX_HRST) begin
                wclass = (wr_data == HRST_MAGIC) ? WC_HR_MAGIC : WC_HR_BAD;
            end else if (int'(reg_idx) < N_STORE) begin
                wclass = WC_PLAIN;
            end else begin
                wclass = WC_VOID;
            end
        end
    end
endmodule

// File: rtl/dctl_bmerge.sv
// Module: merges write data into an old value, lane by lane, under byte
// enables. Assumes DATA_W is a whole number of 8-bit lanes.
module dctl_bmerge #(
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] merged
);
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        // Purpose: pick the new or the old byte for lane b.
        assign merged[8*b +: 8] = be[b] ? new_val[8*b +: 8] : old_val[8*b +: 8];
    end
endmodule

// File: rtl/dctl_irqctl.sv
// Module: owns the interrupt line and the sticky protocol-error flag.
// Assumes the write class is already decoded for this cycle.
module dctl_irqctl
    import dctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wclass_e wclass,
    output logic    irq_o,
    output logic    perr_o
);
    logic irq_set, irq_clr;

    // Purpose: name the events that move the interrupt line.
    always_comb begin
        irq_set = (wclass == WC_CMD_CLK);
        irq_clr = (wclass == WC_BM_RESET) || (wclass == WC_BM_MECHA) ||
                  (wclass == WC_BM_ZERO);
    end

    // Purpose: hold the interrupt level between set and clear events.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_o <= 1'b0;
        else if (irq_set) irq_o <= 1'b1;
        else if (irq_clr) irq_o <= 1'b0;
    end

    // Purpose: latch a refused hard-reset write until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                   perr_o <= 1'b0;
        else if (wclass == WC_HR_BAD) perr_o <= 1'b1;
    end

    AST_IRQ_RISE:   assert property (@(posedge clk) disable iff (!rst_n)
                        wclass == WC_CMD_CLK |=> irq_o);                 // R4
    AST_IRQ_DROP:   assert property (@(posedge clk) disable iff (!rst_n)
                        (wclass == WC_BM_RESET || wclass == WC_BM_MECHA ||
                         wclass == WC_BM_ZERO) |=> !irq_o);              // R8
    AST_IRQ_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                        (wclass == WC_CMD_OTHER || wclass == WC_BM_OTHER) |=> $stable(irq_o)); // R5
    AST_PERR_STICK: assert property (@(posedge clk) disable iff (!rst_n)
                        perr_o |=> perr_o);                              // R11
endmodule

// File: rtl/dctl_regblock.sv
// Module: top of the disk interface register block. Holds the storage
// registers and the read port, and applies the write actions.
// Assumes one bus write per cycle; the reset is synchronous and active low.
module dctl_regblock
    import dctl_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              proto_err_o
);
    logic [DATA_W-1:0] regs_q [N_STORE];
    logic [STORE_W-1:0] slot;
    logic               in_store;
    logic [DATA_W-1:0]  old_val, merged;
    wclass_e            wclass;

    // Purpose: reduce the index to a storage slot and flag whether it is in range.
    always_comb begin
        slot     = reg_idx[STORE_W-1:0];
        in_store = (int'(reg_idx) < N_STORE);
        old_val  = regs_q[slot];
    end

    dctl_wdecode #(.IDX_W(IDX_W)) u_dec (
        .wr_en   (wr_en),
        .reg_idx (reg_idx),
        .wr_data (wr_data),
        .wclass  (wclass)
    );

    dctl_bmerge #(.DATA_W(DATA_W), .BE_W(BE_W)) u_merge (
        .old_val (old_val),
        .new_val (wr_data),
        .be      (wr_be),
        .merged  (merged)
    );

    dctl_irqctl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wclass (wclass),
        .irq_o  (irq_o),
        .perr_o (proto_err_o)
    );

    // Purpose: apply the decoded write action to the storage registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_STORE; i++) regs_q[i] <= '0;
        end else begin
            case (wclass)
                WC_PLAIN, WC_CMD_OTHER, WC_BM_OTHER: regs_q[slot] <= merged;
                WC_CMD_CLK:  regs_q[IDX_CMD]  <= merged | ST_MECH_INT;
                WC_BM_RESET: regs_q[IDX_BMGR] <= regs_q[IDX_BMGR] & ~BM_INTMASK;
                WC_BM_MECHA: regs_q[IDX_CMD]  <= regs_q[IDX_CMD] & ~ST_MECH_INT;
                WC_HR_MAGIC: regs_q[IDX_BMGR] <= BM_C1_DOUBLE;
                default: ;
            endcase
        end
    end

    // Purpose: register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= in_store ? regs_q[slot] : '0;
    end

    AST_HR_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
                      wclass == WC_HR_MAGIC |=> regs_q[IDX_BMGR] == BM_C1_DOUBLE); // R10
    AST_HR_BAD:   assert property (@(posedge clk) disable iff (!rst_n)
                      wclass == WC_HR_BAD |=> $stable(regs_q[IDX_BMGR]) && $stable(regs_q[IDX_CMD])); // R11
    AST_MECH_SET: assert property (@(posedge clk) disable iff (!rst_n)
                      wclass == WC_CMD_CLK |=> (regs_q[IDX_CMD] & ST_MECH_INT) != '0); // R4
    AST_MECH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                      wclass == WC_BM_MECHA |=> (regs_q[IDX_CMD] & ST_MECH_INT) == '0 &&
                                                 $stable(regs_q[IDX_BMGR])); // R7
    AST_ZERO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
                      wclass == WC_BM_ZERO |=> $stable(regs_q[IDX_BMGR]) && $stable(regs_q[IDX_CMD])); // R8
endmodule

// File: tb/sim_dctl_regblock.sv
module sim_dctl_regblock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] rd_data;
    logic        irq_o;
    logic        proto_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dctl_regblock u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_idx(reg_idx), .wr_data(wr_data), .wr_be(wr_be),
        .rd_data(rd_data), .irq_o(irq_o), .proto_err_o(proto_err_o)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] d, logic [3:0] be = 4'hF);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = 4'(idx); wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int idx, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_idx = 4'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        for (int i = 0; i < 9; i++) begin
            rd(i, d);
            check("R1 reg clear", d, 32'h0);
        end
        check("R1 irq low", 32'(irq_o), 32'h0);
        check("R1 perr low", 32'(proto_err_o), 32'h0);
    endtask

    task automatic t_plain();
        logic [31:0] d;
        wr(0, 32'h1122_3344);
        wr(0, 32'hAABB_CCDD, 4'b0101);
        rd(0, d);
        check("R3 byte merge idx0", d, 32'h11BB_33DD);
        wr(7, 32'hCAFE_F00D, 4'b1000);
        rd(7, d);
        check("R3 byte merge idx7", d, 32'hCA00_0000);
    endtask

    task automatic t_read_clean();
        logic [31:0] a, b;
        rd(0, a);
        rd(0, b);
        check("R2 repeat read", b, a);
        check("R2 read no irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_cmd_clock();
        logic [31:0] d;
        wr(2, 32'h0014_0000);
        check("R4 irq after clock read", 32'(irq_o), 32'h1);
        rd(2, d);
        check("R4 mech flag stored", d, 32'h0214_0000);
    endtask

    task automatic t_bm_mecha();
        logic [31:0] d;
        wr(4, 32'h0000_0005);
        wr(2, 32'h0012_0000);
        check("R4 irq year/month", 32'(irq_o), 32'h1);
        wr(4, 32'h0100_0000);
        check("R7 irq dropped", 32'(irq_o), 32'h0);
        rd(2, d);
        check("R7 mech flag cleared", d, 32'h0012_0000);
        rd(4, d);
        check("R7 bm unchanged", d, 32'h0000_0005);
    endtask

    task automatic t_cmd_other();
        logic [31:0] d;
        wr(2, 32'h0001_0001);
        check("R5 irq stays low", 32'(irq_o), 32'h0);
        rd(2, d);
        check("R5 word stored", d, 32'h0001_0001);
        wr(2, 32'h0013_0000);
        wr(2, 32'h000C_0000);
        check("R5 irq stays high", 32'(irq_o), 32'h1);
        rd(2, d);
        check("R5 status request stored", d, 32'h000C_0000);
    endtask

    task automatic t_bm_other_and_reset();
        logic [31:0] d;
        wr(4, 32'h2000_0005);
        check("R9 irq unchanged", 32'(irq_o), 32'h1);
        rd(4, d);
        check("R9 bm merged", d, 32'h2000_0005);
        wr(4, 32'h1000_0000);
        check("R6 irq dropped", 32'(irq_o), 32'h0);
        rd(4, d);
        check("R6 mask cleared", d, 32'h0000_0005);
    endtask

    task automatic t_bm_zero();
        logic [31:0] d;
        wr(2, 32'h0013_0000);
        check("R4 irq day/hour", 32'(irq_o), 32'h1);
        wr(4, 32'h0000_0000);
        check("R8 irq dropped", 32'(irq_o), 32'h0);
        rd(4, d);
        check("R8 bm unchanged", d, 32'h0000_0005);
        rd(2, d);
        check("R8 cmd unchanged", d, 32'h0213_0000);
    endtask

    task automatic t_hard_reset();
        logic [31:0] d;
        wr(8, 32'hAAAA_0000);
        rd(4, d);
        check("R10 bm forced", d, 32'h0040_0000);
        rd(8, d);
        check("R10 hard reset reads 0", d, 32'h0);
        check("R10 no error", 32'(proto_err_o), 32'h0);
        wr(8, 32'h1234_5678);
        check("R11 error set", 32'(proto_err_o), 32'h1);
        rd(4, d);
        check("R11 bm kept", d, 32'h0040_0000);
        rd(2, d);
        check("R11 cmd kept", d, 32'h0213_0000);
        wr(8, 32'hAAAA_0000);
        wr(1, 32'h5);
        check("R11 error sticky", 32'(proto_err_o), 32'h1);
    endtask

    task automatic t_void();
        logic [31:0] d;
        wr(12, 32'hFFFF_FFFF);
        rd(12, d);
        check("R12 void reads 0", d, 32'h0);
        rd(0, d);
        check("R12 idx0 untouched", d, 32'h11BB_33DD);
        rd(4, d);
        check("R12 idx4 untouched", d, 32'h0040_0000);
    endtask

    task automatic t_reset_again();
        logic [31:0] d;
        wr(2, 32'h0014_0000);
        do_reset();
        check("R1 irq cleared", 32'(irq_o), 32'h0);
        check("R1 perr cleared", 32'(proto_err_o), 32'h0);
        rd(2, d);
        check("R1 cmd cleared", d, 32'h0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_read_clean();
        t_cmd_clock();
        t_bm_mecha();
        t_cmd_other();
        t_bm_other_and_reset();
        t_bm_zero();
        t_hard_reset();
        t_void();
        t_reset_again();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule